// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers forty level-sensitive interrupt sources into two 32-bit banks and exposes them to software through a simple single-cycle register bus. Each bank holds a pending register that tracks the source levels, a mask register that enables individual sources, and a steering register that sends each enabled source either to the fast-interrupt line or to the normal-interrupt line. Sources 0 to 31 occupy bits 0 to 31 of bank 0. Sources 32 to 39 occupy bits 0 to 7 of bank 1, and the remaining bank 1 pending bits stay zero.

Forty priority registers hold a valid flag in bit 31 and a 6-bit source number in bits 5:0. A separate resolver reads them and returns a highest-priority result word, which this block only passes through its read path. An idle control bit sets which pending sources can raise the wake-up output while the processor reports itself halted. Clearing the bit lets any pending source wake the core. Setting it limits wake-up to unmasked sources.

Register offsets are byte addresses on an 8-bit address bus, and only word-aligned offsets are mapped. The map is: 0x00 IRQ view, 0x04 mask, 0x08 steering, 0x0C FIQ view, 0x10 raw pending (all bank 0), 0x14 idle control, 0x18 highest-priority result, 0x1C–0x98 priority 0–31, then bank 1 at 0x9C IRQ view, 0xA0 mask, 0xA4 steering, 0xA8 FIQ view, 0xAC raw pending, and 0xB0–0xCC priority 32–39.

Top module: `irqc_banked_regs`

## Requirements
- R1: A source's pending bit equals the source input level sampled at the previous rising clock edge. Source n < 32 maps to bank 0 bit n, and source n ≥ 32 maps to bank 1 bit n−32. Raw pending reads at 0x10 (bank 0) and 0xAC (bank 1).
- R2: A synchronous active-low reset clears pending, mask and steering in both banks, the idle bit, all priority registers and the read data. The source levels present during reset do not appear as pending.
- R3: The mask register (0x04 and 0xA0) and the steering register (0x08 and 0xA4) store a full 32-bit write and read back the stored value. They change on nothing but a write to their own offset.
- R4: The IRQ view (0x00 and 0x9C) reads pending AND mask AND NOT steering. The FIQ view (0x0C and 0xA8) reads pending AND mask AND steering.
- R5: fiq_o is high exactly when some pending, unmasked source has steering bit 1. irq_o is high exactly when some pending, unmasked source has steering bit 0.
- R6: Writing 0x14 stores wdata bit 0. A read of 0x14 returns 1 when the last written bit 0 was 1 and returns 0 otherwise, which includes the state after reset.
- R7: wake_o is high exactly when halt_i is high and some source is pending and either unmasked or allowed because the idle bit is 0.
- R8: A write to priority register k (0x1C+4k for k<32, 0xB0+4(k−32) for k≥32) stores only bit 31 and bits 5:0. All other bits read back as zero.
- R9: A read of 0x18 returns the value of hp_word_i present in the read cycle.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to those offsets, and writes to the views, raw pending and 0x18, change no state.
- R11: Read data appears on rdata_o after the clock edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 40 | Interrupt source levels |
| halt_i | input | 1 | Processor halted indication |
| hp_word_i | input | 32 | Highest-priority word from the external resolver |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast-interrupt request |
| irq_o | output | 1 | Normal-interrupt request |
| wake_o | output | 1 | Wake-up request while halted |

## Verification
The embedded assertions check several properties on every cycle: that pending tracks the sampled source levels, that mask and steering move only on their own writes, that priority writes keep only the allowed fields, that no wake-up is raised without halt, that the fast line never rises without a pending steered source, and that unmapped reads return zero. The bench scenarios cover the behaviour that needs the full address map and a reference model. This includes the class views in both banks, the bank split at source 32, the idle-bit widening of the wake set, pass-through of the resolver word, and the proof that writes to read-only or unmapped offsets leave every readable register unchanged.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the banked interrupt controller.
// Assumes an 8-bit byte address bus and word-aligned register offsets.
package irqc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned WORD_W = ADDR_W - 2;

    typedef logic [WORD_W-1:0] word_t;

    // Per-bank register slots, added to the bank base word
    localparam word_t SLOT_IRQV  = 6'd0;
    localparam word_t SLOT_MASK  = 6'd1;
    localparam word_t SLOT_STEER = 6'd2;
    localparam word_t SLOT_FIQV  = 6'd3;
    localparam word_t SLOT_RAW   = 6'd4;

    localparam word_t BANK0_BASE = 6'd0;   // byte 0x00
    localparam word_t BANK1_BASE = 6'd39;  // byte 0x9C
    localparam word_t W_IDLE     = 6'd5;   // byte 0x14
    localparam word_t W_HP       = 6'd6;   // byte 0x18
    localparam word_t W_PRIO_LO  = 6'd7;   // byte 0x1C, entries 0..31
    localparam word_t W_PRIO_LO_END = 6'd38;
    localparam word_t W_PRIO_HI  = 6'd44;  // byte 0xB0, entries 32..39
    localparam word_t W_PRIO_HI_END = 6'd51;
    localparam word_t PRIO_HI_SHIFT = 6'd12; // word - 12 = entry index

    localparam logic [DATA_W-1:0] PRIO_KEEP = 32'h8000_003F;

    // Word index of a bank slot
    function automatic word_t bank_word(input int b, input word_t slot);
        return ((b == 0) ? BANK0_BASE : BANK1_BASE) + slot;
    endfunction
endpackage

// File: rtl/irqc_bank.sv
// Module: one 32-bit source bank (pending, mask, steering) with class views.
// Assumes src is already aligned to this bank; unused bits are tied low.
module irqc_bank #(
    parameter int unsigned BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  logic              mask_we,
    input  logic              steer_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] steer,
    output logic [BANK_W-1:0] irq_view,
    output logic [BANK_W-1:0] fiq_view
);
    logic [BANK_W-1:0] pend_q, mask_q, steer_q;

    // Pending bits sample the source levels each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src;
    end

    // Mask and steering registers take full-width writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            steer_q <= '0;
        end else begin
            if (mask_we)  mask_q  <= wdata;
            if (steer_we) steer_q <= wdata;
        end
    end

    // Class views of the enabled pending sources
    always_comb begin
        irq_view = pend_q & mask_q & ~steer_q;
        fiq_view = pend_q & mask_q & steer_q;
    end

    assign pend  = pend_q;
    assign mask  = mask_q;
    assign steer = steer_q;

    p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(src));
    p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(wdata));
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
    p_steer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !steer_we |=> $stable(steer_q));
endmodule

// File: rtl/irqc_prio_file.sv
// Module: priority register file; each entry keeps a valid flag and a source id.
// Assumes the caller only raises we with an in-range index.
module irqc_prio_file #(
    parameter int unsigned NUM   = 40,
    parameter int unsigned IDX_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [irqc_pkg::DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [irqc_pkg::DATA_W-1:0] rd_data
);
    import irqc_pkg::*;

    logic [DATA_W-1:0] prio_q [NUM];

    // Per-entry storage with field filtering on write
    for (genvar k = 0; k < NUM; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                                  prio_q[k] <= '0;
            else if (we && wr_idx == IDX_W'(k))          prio_q[k] <= wdata & PRIO_KEEP;
        end
    end

    // Read selection, zero for an index beyond the file
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM; k++)
            if (rd_idx == IDX_W'(k)) rd_data = prio_q[k];
    end

    p_prio_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx < IDX_W'(NUM)) |=> prio_q[$past(wr_idx)] == ($past(wdata) & PRIO_KEEP));
endmodule

// File: rtl/irqc_banked_regs.sv
// Module: top of the banked interrupt controller. It decodes the register bus,
// registers read data, holds the idle bit and drives the fiq/irq/wake lines.
// Assumes a single-cycle bus: one access per cycle while bus_sel_i is high.
module irqc_banked_regs #(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned BANK_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [39:0] src_i,
    input  logic        halt_i,
    input  logic [31:0] hp_word_i,
    input  logic        bus_sel_i,
    input  logic        bus_we_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        fiq_o,
    output logic        irq_o,
    output logic        wake_o
);
    import irqc_pkg::*;

    localparam int unsigned NBANK  = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int unsigned PAD_W  = NBANK * BANK_W;
    localparam int unsigned PIDX_W = $clog2(NUM_SRC);

    logic                          bus_wr, bus_rd, aligned;
    word_t                         word;
    logic [PAD_W-1:0]              src_pad;
    logic [NBANK-1:0]              mask_we, steer_we;
    logic [NBANK-1:0][BANK_W-1:0]  pend_b, mask_b, steer_b, irqv_b, fiqv_b;
    logic                          idle_q;
    logic                          prio_hit;
    logic [PIDX_W-1:0]             prio_idx;
    logic [DATA_W-1:0]             prio_rd;
    logic [DATA_W-1:0]             rd_next;
    logic                          rd_hit;
    logic [BANK_W-1:0]             wake_any;

    // Bus qualifiers and word index
    always_comb begin
        bus_wr  = bus_sel_i && bus_we_i;
        bus_rd  = bus_sel_i && !bus_we_i;
        aligned = (bus_addr_i[1:0] == 2'b00);
        word    = bus_addr_i[ADDR_W-1:2];
    end

    // Spread sources over the banks, padding the top bank with zeros
    always_comb begin
        src_pad = '0;
        src_pad[NUM_SRC-1:0] = src_i;
    end

    // Priority register index decode for both address windows
    always_comb begin
        prio_hit = 1'b0;
        prio_idx = '0;
        if (aligned && word >= W_PRIO_LO && word <= W_PRIO_LO_END) begin
            prio_hit = 1'b1;
            prio_idx = PIDX_W'(word - W_PRIO_LO);
        end else if (aligned && word >= W_PRIO_HI && word <= W_PRIO_HI_END) begin
            prio_hit = 1'b1;
            prio_idx = PIDX_W'(word - PRIO_HI_SHIFT);
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Per-bank write strobes
        always_comb begin
            mask_we[b]  = bus_wr && aligned && word == bank_word(b, SLOT_MASK);
            steer_we[b] = bus_wr && aligned && word == bank_word(b, SLOT_STEER);
        end

        irqc_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src_pad[b*BANK_W +: BANK_W]),
            .mask_we  (mask_we[b]),
            .steer_we (steer_we[b]),
            .wdata    (bus_wdata_i),
            .pend     (pend_b[b]),
            .mask     (mask_b[b]),
            .steer    (steer_b[b]),
            .irq_view (irqv_b[b]),
            .fiq_view (fiqv_b[b])
        );
    end

    irqc_prio_file #(.NUM(NUM_SRC), .IDX_W(PIDX_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_wr && prio_hit),
        .wr_idx  (prio_idx),
        .wdata   (bus_wdata_i),
        .rd_idx  (prio_idx),
        .rd_data (prio_rd)
    );

    // Idle control bit: 1 restricts wake-up to unmasked sources
    always_ff @(posedge clk) begin
        if (!rst_n)                                  idle_q <= 1'b0;
        else if (bus_wr && aligned && word == W_IDLE) idle_q <= bus_wdata_i[0];
    end

    // Read multiplexer over the whole map
    always_comb begin
        rd_next = '0;
        rd_hit  = 1'b1;
        if (!aligned)              rd_hit = 1'b0;
        else if (prio_hit)         rd_next = prio_rd;
        else if (word == W_IDLE)   rd_next = {{(DATA_W-1){1'b0}}, idle_q};
        else if (word == W_HP)     rd_next = hp_word_i;
        else begin
            rd_hit = 1'b0;
            for (int b = 0; b < NBANK; b++) begin
                if (word == bank_word(b, SLOT_IRQV))  begin rd_next = irqv_b[b];  rd_hit = 1'b1; end
                if (word == bank_word(b, SLOT_MASK))  begin rd_next = mask_b[b];  rd_hit = 1'b1; end
                if (word == bank_word(b, SLOT_STEER)) begin rd_next = steer_b[b]; rd_hit = 1'b1; end
                if (word == bank_word(b, SLOT_FIQV))  begin rd_next = fiqv_b[b];  rd_hit = 1'b1; end
                if (word == bank_word(b, SLOT_RAW))   begin rd_next = pend_b[b];  rd_hit = 1'b1; end
            end
        end
    end

    // Read data register, updated only on reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata_o <= '0;
        else if (bus_rd) bus_rdata_o <= rd_next;
    end

    // Interrupt and wake-up outputs from the bank state
    always_comb begin
        fiq_o    = 1'b0;
        irq_o    = 1'b0;
        wake_any = '0;
        for (int b = 0; b < NBANK; b++) begin
            fiq_o    = fiq_o | (|fiqv_b[b]);
            irq_o    = irq_o | (|irqv_b[b]);
            wake_any = wake_any | (pend_b[b] & (mask_b[b] | {BANK_W{~idle_q}}));
        end
        wake_o = halt_i && (|wake_any);
    end

    p_wake_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_i |-> !wake_o);
    p_fiq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (|(pend_b & mask_b & steer_b)));
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_hit) |=> bus_rdata_o == '0);
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata_o));
    p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && aligned && word == W_IDLE) |=> bus_rdata_o == {31'b0, $past(idle_q)});
endmodule

// File: tb/tb_irqc_banked_regs.sv
module tb_irqc_banked_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_i = '0;
    logic        halt_i = 1'b0;
    logic [31:0] hp_word_i = '0;
    logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        fiq_o, irq_o, wake_o;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] m_pend [2];
    logic [31:0] m_mask [2];
    logic [31:0] m_steer[2];
    logic        m_idle;
    logic [31:0] m_prio [40];

    irqc_banked_regs dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .halt_i(halt_i),
        .hp_word_i(hp_word_i), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .fiq_o(fiq_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] a_irqv(int b);  return b ? 8'h9C : 8'h00; endfunction
    function automatic logic [7:0] a_mask(int b);  return b ? 8'hA0 : 8'h04; endfunction
    function automatic logic [7:0] a_steer(int b); return b ? 8'hA4 : 8'h08; endfunction
    function automatic logic [7:0] a_fiqv(int b);  return b ? 8'hA8 : 8'h0C; endfunction
    function automatic logic [7:0] a_raw(int b);   return b ? 8'hAC : 8'h10; endfunction
    function automatic logic [7:0] a_prio(int k);
        return (k < 32) ? 8'(8'h1C + 4*k) : 8'(8'hB0 + 4*(k-32));
    endfunction

    function automatic logic exp_fiq();
        return |(m_pend[0] & m_mask[0] & m_steer[0]) | |(m_pend[1] & m_mask[1] & m_steer[1]);
    endfunction
    function automatic logic exp_irq();
        return |(m_pend[0] & m_mask[0] & ~m_steer[0]) | |(m_pend[1] & m_mask[1] & ~m_steer[1]);
    endfunction
    function automatic logic exp_wake();
        logic [31:0] allow = m_idle ? 32'h0 : 32'hFFFF_FFFF;
        return halt_i && (|(m_pend[0] & (m_mask[0] | allow)) || |(m_pend[1] & (m_mask[1] | allow)));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_sel_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic set_src(input logic [39:0] v);
        @(negedge clk);
        src_i = v;
        m_pend[0] = v[31:0];
        m_pend[1] = {24'b0, v[39:32]};
        @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        chk({"R5 fiq ", tag}, {31'b0, fiq_o}, {31'b0, exp_fiq()});
        chk({"R5 irq ", tag}, {31'b0, irq_o}, {31'b0, exp_irq()});
        chk({"R7 wake ", tag}, {31'b0, wake_o}, {31'b0, exp_wake()});
    endtask

    task automatic check_bank_regs();
        logic [31:0] d;
        for (int b = 0; b < 2; b++) begin
            do_read(a_raw(b), d);   chk("R1 raw pending", d, m_pend[b]);
            do_read(a_mask(b), d);  chk("R3 mask readback", d, m_mask[b]);
            do_read(a_steer(b), d); chk("R3 steering readback", d, m_steer[b]);
            do_read(a_irqv(b), d);  chk("R4 irq view", d, m_pend[b] & m_mask[b] & ~m_steer[b]);
            do_read(a_fiqv(b), d);  chk("R4 fiq view", d, m_pend[b] & m_mask[b] & m_steer[b]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        void'($urandom(32'd1234));
        for (int b = 0; b < 2; b++) begin
            m_pend[b] = '0; m_mask[b] = '0; m_steer[b] = '0;
        end
        m_idle = 1'b0;
        for (int k = 0; k < 40; k++) m_prio[k] = '0;

        // R2: sources high throughout reset must not show as pending
        src_i = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 fiq after reset", {31'b0, fiq_o}, 32'h0);
        chk("R2 irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R2 rdata after reset", bus_rdata_o, 32'h0);
        set_src('0);
        check_bank_regs();
        do_read(8'h14, d);   chk("R6 idle reads 0 after reset", d, 32'h0);
        do_read(a_prio(5), d); chk("R2 priority cleared", d, 32'h0);

        // R1: bank split at source 32 and 31
        m_mask[0] = 32'h8000_0000; do_write(a_mask(0), m_mask[0]);
        m_mask[1] = 32'h0000_0001; do_write(a_mask(1), m_mask[1]);
        set_src(40'h01_0000_0000);
        do_read(a_raw(1), d); chk("R1 source 32 to bank1 bit0", d, 32'h1);
        do_read(a_raw(0), d); chk("R1 bank0 empty", d, 32'h0);
        check_outputs("source 32");
        set_src(40'h00_8000_0000);
        do_read(a_raw(0), d); chk("R1 source 31 to bank0 bit31", d, 32'h8000_0000);
        check_outputs("source 31");

        // R7: idle bit changes the wake set
        m_mask[0] = 0; do_write(a_mask(0), 0);
        @(negedge clk); halt_i = 1'b1;
        @(negedge clk); check_outputs("masked pending idle 0");
        chk("R7 wake from masked source", {31'b0, wake_o}, 32'h1);
        m_idle = 1'b1; do_write(8'h14, 32'hFFFF_FFFF);
        check_outputs("masked pending idle 1");
        chk("R7 no wake when idle restricts", {31'b0, wake_o}, 32'h0);
        do_read(8'h14, d); chk("R6 idle reads 1", d, 32'h1);
        m_idle = 1'b0; do_write(8'h14, 32'hFFFF_FFFE);
        do_read(8'h14, d); chk("R6 idle reads 0 after bit0 clear", d, 32'h0);
        @(negedge clk); halt_i = 1'b0;
        @(negedge clk); check_outputs("halt low");

        // R8: priority field filtering, both windows and edges
        for (int k = 0; k < 40; k++) begin
            v = $urandom;
            m_prio[k] = v & 32'h8000_003F;
            do_write(a_prio(k), v);
        end
        foreach (m_prio[k]) begin
            do_read(a_prio(k), d);
            chk("R8 priority readback", d, m_prio[k]);
        end
        do_write(a_prio(39), 32'hFFFF_FFFF); m_prio[39] = 32'h8000_003F;
        do_read(a_prio(39), d); chk("R8 all-ones filtered", d, 32'h8000_003F);

        // R9: resolver word passes through
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); hp_word_i = $urandom;
            do_read(8'h18, d); chk("R9 highest-priority passthrough", d, hp_word_i);
        end

        // R11: read data holds between reads
        do_read(a_prio(3), d);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", bus_rdata_o, m_prio[3]);

        // R10: unmapped and misaligned reads, ignored writes
        do_read(8'hD0, d); chk("R10 unmapped read D0", d, 32'h0);
        do_read(8'hFC, d); chk("R10 unmapped read FC", d, 32'h0);
        do_read(8'h05, d); chk("R10 misaligned read", d, 32'h0);
        m_mask[0] = 32'h0F0F_0F0F; do_write(a_mask(0), m_mask[0]);
        m_steer[0] = 32'h00FF_00FF; do_write(a_steer(0), m_steer[0]);
        set_src(40'hAA_5555_AAAA);
        do_write(8'hD0, 32'hFFFF_FFFF);
        do_write(8'h05, 32'hFFFF_FFFF);
        do_write(8'h00, 32'hFFFF_FFFF);
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'hAC, 32'hFFFF_FFFF);
        do_write(8'h18, 32'hFFFF_FFFF);
        do_write(8'h0C, 32'hFFFF_FFFF);
        check_bank_regs();
        do_read(8'h14, d); chk("R10 idle untouched", d, 32'h0);
        do_read(a_prio(0), d); chk("R10 priority 0 untouched", d, m_prio[0]);
        check_outputs("after ignored writes");

        // Random mix: R1 R3 R4 R5 R7
        for (int it = 0; it < 40; it++) begin
            int b = int'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: begin m_mask[b] = $urandom; do_write(a_mask(b), m_mask[b]); end
                1: begin m_steer[b] = $urandom; do_write(a_steer(b), m_steer[b]); end
                2: begin v = $urandom; m_idle = v[0]; do_write(8'h14, v); end
                default: set_src({8'($urandom), 32'($urandom)});
            endcase
            @(negedge clk); halt_i = 1'($urandom);
            @(negedge clk); check_outputs("random");
            if (it % 8 == 0) check_bank_regs();
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule